// File: doc/BRIEF.md
# Table-Encoded Clock Divider Path

This block derives one slow clock from two candidate source clocks, modelled as clock-enable strobes in a single system clock domain. A selection bit chooses which source is counted. An enable bit gates the whole path. A 3-bit code sets the division ratio. The code does not mean "divide by code plus one". It is looked up in one of four encoding tables, fixed per instance when the block is built. In some tables two codes give the same ratio.

The result is available in two forms, both registered:
- a one-cycle pulse at the close of each output period, usable as a clock enable downstream;
- a level that is high for the first half of each period, which gives an exact 50% duty when the ratio is even.

All three controls are read from fixed bit positions of one 32-bit selection word. The other bits of that word belong to neighbouring functions and are ignored here. When source 0 is selected it is first halved by a prescaler, so it behaves as a fast source running at half rate.

Top module: `ckdiv_path`

## Requirements
- R1: While `rst` is high at a clock edge, both `div_tick` and `div_clk` are low after that edge, and the period count restarts from zero.
- R2: With the even table (default), code k gives a period of 2×(k+1) counted source ticks, so codes 0..7 map to ratios 2, 4, 6, 8, 10, 12, 14 and 16.
- R3: With the network table, codes 0 and 1 both give a ratio of 4, and codes 2..7 give 2×(k+1), up to 16.
- R4: With the video table, codes 0 and 1 both give a ratio of 2, and codes 2..7 give k+1, up to 8.
- R5: With the coarse table, code k gives a ratio of 4×(k+1), so codes 0..7 map to 4 through 32.
- R6: The fields sit in `sel_reg` at fixed positions:
  - bit 11 selects the source (0 = source 0 after the prescaler, 1 = source 1);
  - bit 15 enables the path when 1;
  - bits 14:12 hold the ratio code.
  All other bits of `sel_reg` have no effect on either output.
- R7: The source 0 strobe is halved before counting. Its first, third, fifth and later odd strobes after enable or reset are dropped, and its even-numbered strobes count. The prescaler runs on every source 0 strobe while the path is enabled, whichever source is selected. Source 1 strobes count directly.
- R8: In a cycle where bit 15 is 0:
  - both outputs are low after the next edge;
  - the period count and the prescaler are cleared;
  - the latest code is loaded.
  When the path is re-enabled, a fresh period starts, with `div_clk` high in the first cycle.
- R9: A changed code is taken only at the close of the current period (or while the path is disabled). The running period always completes with the ratio it started with.
- R10: `div_tick` is high for exactly one cycle, one cycle after the edge on which the R-th tick of a period is counted. `div_clk` is high while the count within the period is below floor(R/2), so it is high in the cycle that `div_tick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state and both outputs are registered on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_reg | input | 32 | Selection word carrying source select, enable and ratio code |
| src0_tick | input | 1 | Strobe from the fast source; halved before counting |
| src1_tick | input | 1 | Strobe from the alternate source; counted directly |
| div_tick | output | 1 | One-cycle pulse marking the end of each output period |
| div_clk | output | 1 | Divided clock level, high for the first half of each period |

## Verification
Two pairs of events can land on the same clock edge:
- the period wrap, which loads a new ratio, and a code rewrite in `sel_reg`;
- the final counted tick of a period and the enable bit falling.

Both pairs are provoked in two ways. One phase rewrites the code every few cycles while source 1 ticks continuously. The closing phase randomises the code, both strobes, the select bit and the enable bit on every cycle.

The bench holds a behavioural model of count, ratio and prescaler for each of four instances, one per table. It compares both outputs of every instance against that model on every clock. A ratio taken mid-period, or a tick issued after the enable dropped, shows up as a mismatch in the cycle where it occurs.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;

  // Encoding tables that turn a ratio code into a divide ratio.
  typedef enum logic [1:0] {
    TBL_EVEN   = 2'd0,
    TBL_MAC    = 2'd1,
    TBL_VIDEO  = 2'd2,
    TBL_COARSE = 2'd3
  } ckdiv_tbl_e;

  // Divide ratio produced by a code under a given table.
  function automatic int unsigned ckdiv_ratio(ckdiv_tbl_e tbl, int unsigned code);
    int unsigned r;
    case (tbl)
      TBL_EVEN:   r = 2 * (code + 1);
      TBL_MAC:    r = (code < 2) ? 4 : 2 * (code + 1);
      TBL_VIDEO:  r = (code < 2) ? 2 : code + 1;
      default:    r = 4 * (code + 1);
    endcase
    return r;
  endfunction

  // Largest ratio any code of a DIV_W-bit field can select.
  function automatic int unsigned ckdiv_max_ratio(ckdiv_tbl_e tbl, int unsigned div_w);
    int unsigned m;
    m = 0;
    for (int unsigned k = 0; k < (1 << div_w); k++) begin
      if (ckdiv_ratio(tbl, k) > m) m = ckdiv_ratio(tbl, k);
    end
    return m;
  endfunction

endpackage

// File: rtl/ckdiv_field_dec.sv
module ckdiv_field_dec
  import ckdiv_pkg::*;
#(
  parameter ckdiv_tbl_e TABLE   = TBL_EVEN,
  parameter int         REG_W   = 32,
  parameter int         SEL_BIT = 11,
  parameter int         GATE_BIT = 15,
  parameter int         DIV_LSB = 12,
  parameter int         DIV_W   = 3,
  parameter int         RW      = 6
) (
  input  logic [REG_W-1:0] sel_reg,
  output logic             src_sel,
  output logic             gate_en,
  output logic [RW-1:0]    ratio
);

  logic [DIV_W-1:0] code;
  logic             unused_bits;

  assign src_sel     = sel_reg[SEL_BIT];
  assign gate_en     = sel_reg[GATE_BIT];
  assign code        = sel_reg[DIV_LSB +: DIV_W];
  // Remaining bits belong to neighbouring functions.
  assign unused_bits = ^sel_reg;

  // One table is built per instance.
  generate
    if (TABLE == TBL_EVEN) begin : g_even
      assign ratio = RW'(2 * (int'(code) + 1));
    end else if (TABLE == TBL_MAC) begin : g_mac
      assign ratio = (code < DIV_W'(2)) ? RW'(4) : RW'(2 * (int'(code) + 1));
    end else if (TABLE == TBL_VIDEO) begin : g_video
      assign ratio = (code < DIV_W'(2)) ? RW'(2) : RW'(int'(code) + 1);
    end else begin : g_coarse
      assign ratio = RW'(4 * (int'(code) + 1));
    end
  endgenerate

endmodule

// File: rtl/ckdiv_src_sel.sv
module ckdiv_src_sel #(
  parameter int SRC0_PREDIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_en,
  input  logic src_sel,
  input  logic src0_tick,
  input  logic src1_tick,
  output logic tick
);

  logic src0_eff;

  generate
    if (SRC0_PREDIV == 2) begin : g_half
      // Phase flop: the second strobe of each pair is passed on.
      logic phase_q;
      always_ff @(posedge clk) begin
        if (rst || !gate_en) begin
          phase_q <= 1'b0;
        end else if (src0_tick) begin
          phase_q <= ~phase_q;
        end
      end
      assign src0_eff = src0_tick & phase_q;
    end else begin : g_direct
      logic unused_ctl;
      assign unused_ctl = clk ^ rst ^ gate_en;
      assign src0_eff   = src0_tick;
    end
  endgenerate

  // Synchronous switch between the two strobe streams.
  assign tick = src_sel ? src1_tick : src0_eff;

endmodule

// File: rtl/ckdiv_counter.sv
module ckdiv_counter #(
  parameter int RW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gate_en,
  input  logic          tick,
  input  logic [RW-1:0] ratio_new,
  output logic          div_tick,
  output logic          div_clk
);

  logic [RW-1:0] cnt_q, cnt_n;
  logic [RW-1:0] rat_q, rat_n;
  logic          wrap;

  // Last tick of the running period.
  assign wrap = gate_en && tick && (cnt_q == rat_q - RW'(1));

  always_comb begin
    cnt_n = cnt_q;
    rat_n = rat_q;
    if (!gate_en) begin
      cnt_n = '0;
      rat_n = ratio_new;
    end else if (tick) begin
      if (wrap) begin
        cnt_n = '0;
        rat_n = ratio_new;   // new code only at the period boundary
      end else begin
        cnt_n = cnt_q + RW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      rat_q    <= ratio_new;
      div_tick <= 1'b0;
      div_clk  <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      rat_q    <= rat_n;
      div_tick <= wrap;
      div_clk  <= gate_en && (cnt_n < (rat_n >> 1));
    end
  end

endmodule

// File: rtl/ckdiv_path.sv
module ckdiv_path
  import ckdiv_pkg::*;
#(
  parameter ckdiv_tbl_e TABLE       = TBL_EVEN,
  parameter int         REG_W       = 32,
  parameter int         SEL_BIT     = 11,
  parameter int         GATE_BIT    = 15,
  parameter int         DIV_LSB     = 12,
  parameter int         DIV_W       = 3,
  parameter int         SRC0_PREDIV = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] sel_reg,
  input  logic             src0_tick,
  input  logic             src1_tick,
  output logic             div_tick,
  output logic             div_clk
);

  localparam int unsigned MAX_RATIO = ckdiv_max_ratio(TABLE, DIV_W);
  localparam int          RW        = $clog2(MAX_RATIO + 1);

  logic          src_sel;
  logic          gate_en;
  logic [RW-1:0] ratio;
  logic          tick;

  ckdiv_field_dec #(
    .TABLE(TABLE), .REG_W(REG_W), .SEL_BIT(SEL_BIT), .GATE_BIT(GATE_BIT),
    .DIV_LSB(DIV_LSB), .DIV_W(DIV_W), .RW(RW)
  ) u_dec (
    .sel_reg(sel_reg),
    .src_sel(src_sel),
    .gate_en(gate_en),
    .ratio  (ratio)
  );

  ckdiv_src_sel #(
    .SRC0_PREDIV(SRC0_PREDIV)
  ) u_src (
    .clk      (clk),
    .rst      (rst),
    .gate_en  (gate_en),
    .src_sel  (src_sel),
    .src0_tick(src0_tick),
    .src1_tick(src1_tick),
    .tick     (tick)
  );

  ckdiv_counter #(
    .RW(RW)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .gate_en  (gate_en),
    .tick     (tick),
    .ratio_new(ratio),
    .div_tick (div_tick),
    .div_clk  (div_clk)
  );

endmodule

// File: rtl/ckdiv_path_chk.sv
module ckdiv_path_chk #(
  parameter int REG_W    = 32,
  parameter int GATE_BIT = 15
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] sel_reg,
  input logic             src0_tick,
  input logic             src1_tick,
  input logic             div_tick,
  input logic             div_clk
);

  // R1: reset silences both outputs
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!div_tick && !div_clk));

  // R8: a disabled path drives nothing
  p_gate_off_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !sel_reg[GATE_BIT] |=> (!div_tick && !div_clk));

  // R10: the period pulse lasts one cycle
  p_tick_single_r10: assert property (@(posedge clk) disable iff (rst)
    div_tick |=> !div_tick);

  // R10: each new period starts in the high half
  p_tick_in_high_half_r10: assert property (@(posedge clk) disable iff (rst)
    div_tick |-> div_clk);

  // R7: a period can only close on a source strobe
  p_tick_has_source_r7: assert property (@(posedge clk) disable iff (rst)
    div_tick |-> $past(src0_tick || src1_tick));

endmodule

bind ckdiv_path ckdiv_path_chk #(.REG_W(REG_W), .GATE_BIT(GATE_BIT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sel_reg  (sel_reg),
  .src0_tick(src0_tick),
  .src1_tick(src1_tick),
  .div_tick (div_tick),
  .div_clk  (div_clk)
);

// File: tb/ckdiv_path_tb.sv
`timescale 1ns/1ps
module ckdiv_path_tb;
  import ckdiv_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] sel_reg = '0;
  logic        src0_tick = 1'b0;
  logic        src1_tick = 1'b0;
  logic [3:0]  o_tick;
  logic [3:0]  o_clk;

  always #2 clk = ~clk;   // 250 MHz

  // One instance per table: R2 even, R3 network, R4 video, R5 coarse.
  ckdiv_path #(.TABLE(TBL_EVEN)) u_dut (
    .clk(clk), .rst(rst), .sel_reg(sel_reg), .src0_tick(src0_tick),
    .src1_tick(src1_tick), .div_tick(o_tick[0]), .div_clk(o_clk[0]));
  ckdiv_path #(.TABLE(TBL_MAC)) u_mac (
    .clk(clk), .rst(rst), .sel_reg(sel_reg), .src0_tick(src0_tick),
    .src1_tick(src1_tick), .div_tick(o_tick[1]), .div_clk(o_clk[1]));
  ckdiv_path #(.TABLE(TBL_VIDEO)) u_ve (
    .clk(clk), .rst(rst), .sel_reg(sel_reg), .src0_tick(src0_tick),
    .src1_tick(src1_tick), .div_tick(o_tick[2]), .div_clk(o_clk[2]));
  ckdiv_path #(.TABLE(TBL_COARSE)) u_crs (
    .clk(clk), .rst(rst), .sel_reg(sel_reg), .src0_tick(src0_tick),
    .src1_tick(src1_tick), .div_tick(o_tick[3]), .div_clk(o_clk[3]));

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    started = 0;
  string cur_req = "R1";
  string tbl_req[4] = '{"R2", "R3", "R4", "R5"};

  // Reference model state.
  int m_cnt[4];
  int m_rat[4];
  bit m_pre;
  bit e_tick[4];
  bit e_clk[4];

  // R2..R5 tables written from the requirements.
  function automatic int ref_ratio(int tbl, int k);
    case (tbl)
      0:       return 2 * (k + 1);
      1:       return (k < 2) ? 4 : 2 * (k + 1);
      2:       return (k < 2) ? 2 : k + 1;
      default: return 4 * (k + 1);
    endcase
  endfunction

  // Model step at each rising edge using the inputs held before it.
  always @(posedge clk) begin
    bit g, s, t;
    int k;
    g = sel_reg[15];
    s = sel_reg[11];
    k = int'(sel_reg[14:12]);
    started = 1;
    if (rst) begin
      m_pre = 0;
      for (int i = 0; i < 4; i++) begin
        m_cnt[i] = 0; m_rat[i] = ref_ratio(i, k);
        e_tick[i] = 0; e_clk[i] = 0;
      end
    end else begin
      t = s ? src1_tick : (src0_tick && m_pre);
      if (!g) m_pre = 0;
      else if (src0_tick) m_pre = !m_pre;
      for (int i = 0; i < 4; i++) begin
        if (!g) begin
          m_cnt[i] = 0; m_rat[i] = ref_ratio(i, k);
          e_tick[i] = 0; e_clk[i] = 0;
        end else begin
          e_tick[i] = t && (m_cnt[i] == m_rat[i] - 1);
          if (t) begin
            if (e_tick[i]) begin
              m_cnt[i] = 0; m_rat[i] = ref_ratio(i, k);
            end else begin
              m_cnt[i] = m_cnt[i] + 1;
            end
          end
          e_clk[i] = m_cnt[i] < (m_rat[i] / 2);
        end
      end
    end
  end

  // Compare away from the active edge.
  always @(negedge clk) begin
    if (started) begin
      for (int i = 0; i < 4; i++) begin
        n_cmp++;
        if (o_tick[i] !== e_tick[i]) begin
          n_bad++;
          $display("FAIL %s/%s inst %0d div_tick actual %b expected %b cyc %0d",
                   cur_req, tbl_req[i], i, o_tick[i], e_tick[i], cyc);
        end
        n_cmp++;
        if (o_clk[i] !== e_clk[i]) begin
          n_bad++;
          $display("FAIL %s/%s inst %0d div_clk actual %b expected %b cyc %0d",
                   cur_req, tbl_req[i], i, o_clk[i], e_clk[i], cyc);
        end
      end
    end
  end

  // Watchdog.
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // R6: unrelated bits are randomised on every drive.
  task automatic drive(input bit g, input bit s, input int c, input bit t0, input bit t1);
    @(negedge clk);
    sel_reg        = $urandom;
    sel_reg[15]    = g;
    sel_reg[11]    = s;
    sel_reg[14:12] = 3'(c);
    src0_tick      = t0;
    src1_tick      = t1;
  endtask

  initial begin
    // R1: reset state, with the path enabled in the word
    cur_req = "R1";
    sel_reg = 32'h0000_8800;
    repeat (4) @(negedge clk);
    @(negedge clk) rst = 1'b0;
    repeat (3) drive(0, 1, 0, 1, 1);
    // R6: every code on source 1, continuous strobes, noisy neighbour bits
    cur_req = "R6";
    for (int c = 0; c < 8; c++) begin
      repeat (70) drive(1, 1, c, 1'($urandom), 1);
    end
    // R9: code rewritten every few cycles, mid-period
    cur_req = "R9";
    for (int n = 0; n < 60; n++) begin
      int c;
      c = $urandom_range(0, 7);
      repeat (5) drive(1, 1, c, 0, 1);
    end
    // R7: source 0 through the prescaler, steady then sparse
    cur_req = "R7";
    repeat (200) drive(1, 0, 2, 1, 1'($urandom));
    repeat (300) drive(1, 0, 5, 1'($urandom), 1'($urandom));
    // R8: enable dropped and restored mid-period
    cur_req = "R8";
    for (int n = 0; n < 12; n++) begin
      repeat (23) drive(1, 1, 3, 0, 1'($urandom));
      repeat (7)  drive(0, 1, 3, 1'($urandom), 1);
    end
    // R1: reset applied while running
    cur_req = "R1";
    repeat (20) drive(1, 1, 6, 0, 1);
    @(negedge clk) rst = 1'b1;
    repeat (3) drive(1, 1, 6, 0, 1);
    @(negedge clk) rst = 1'b0;
    repeat (40) drive(1, 1, 6, 0, 1);
    // R10: everything random, enable mostly on
    cur_req = "R10";
    repeat (3000) drive(($urandom_range(0, 9) != 0), 1'($urandom),
                        $urandom_range(0, 7), 1'($urandom), 1'($urandom));
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule